// File: doc/BRIEF.md
# Register Renaming Unit with Free-Register Queue

This block renames the architectural registers of a small out-of-order core onto a larger pool of physical registers. Each cycle it takes a group of up to `LANES` decoded instructions. Every instruction names two source registers and one destination register out of 32 logical registers. For each instruction the block returns the physical tags of both sources and a freshly allocated physical tag for the destination. When the pool cannot cover the whole group, it raises a stall instead.

The block keeps two mapping tables. The speculative table is read and written at rename time. The committed table advances only when the back end reports, in program order, that an instruction has retired. At retirement no register value moves. The committed table is pointed at the new tag, and the tag that previously held the committed value of that logical register goes back into the pool. A recovery request discards all speculative work: the speculative table is reloaded from the committed table, and every tag handed out since the committed point becomes free again.

The free pool is a circular queue whose length is the number of spare physical registers. Tags are allocated at the head and released at the tail. Because retirement frees exactly one tag for each tag it consumes, recovery only has to move the head pointer back to the committed position.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i (0 to 31) reads physical tag i, and the spare tags 32 to NUM_PHYS-1 are handed out in ascending order.
- R2: Each source tag comes from the speculative table. The destination tags of a group come from the free queue head, given to the valid lanes in ascending lane order. A stall-free group with at least one valid lane consumes one queue entry per valid lane.
- R3: An accepted rename writes its destination tag into the speculative table, so that renames in later cycles read it. If two lanes of one group name the same destination, the higher lane's tag is the one kept.
- R4: `ren_stall` is high whenever the valid lanes outnumber the free tags. A stalled group is dropped whole: nothing is allocated and the speculative table is unchanged.
- R5: Within a group, a source that matches the destination of a lower valid lane takes that lane's new tag (the highest such lower lane), not the table entry.
- R6: A commit (`cmt_valid`, `cmt_log`, `cmt_phys`) sets the committed entry of `cmt_log` to `cmt_phys`. The tag that entry held before goes to the tail of the free queue. It is usable from the next cycle, not the cycle of the commit.
- R7: During a cycle with `recover` high, `ren_stall` is high and the group is dropped. From the next cycle the speculative table equals the committed table, including a commit made in that same cycle. All uncommitted tags sit at the front of the free queue in their allocation order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | LANES | Per-lane rename request |
| ren_src_a | input | LANES x 5 | First source logical register per lane |
| ren_src_b | input | LANES x 5 | Second source logical register per lane |
| ren_dst | input | LANES x 5 | Destination logical register per lane |
| ren_tag_a | output | LANES x PW | Physical tag of the first source |
| ren_tag_b | output | LANES x PW | Physical tag of the second source |
| ren_tag_d | output | LANES x PW | Newly allocated destination tag |
| ren_stall | output | 1 | Group not accepted this cycle |
| cmt_valid | input | 1 | Oldest in-flight instruction retires |
| cmt_log | input | 5 | Logical destination of the retiring instruction |
| cmt_phys | input | PW | Physical tag given to the retiring instruction |
| recover | input | 1 | Discard all uncommitted renames |

## Verification
The assertions take for granted that commits arrive in allocation order and carry the tag and logical register that the oldest uncommitted rename received. They also assume a commit is never issued with nothing in flight. Under those conditions the free count can never exceed the number of spare tags. The bench keeps its own queue of in-flight renames and drives each commit from the front of that queue. It issues a commit only while the queue holds an entry, and it recovers at random points, including points in the same cycle as a commit.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned RN_LOG_REGS = 32;
    localparam int unsigned RN_LOG_W    = 5;
    typedef logic [RN_LOG_W-1:0] lreg_t;
endpackage

// File: rtl/rn_free_queue.sv
module rn_free_queue #(
    parameter int unsigned NUM_PHYS = 64,
    parameter int unsigned LANES    = 2,
    localparam int unsigned NPR     = NUM_PHYS - rn_pkg::RN_LOG_REGS,
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned IW      = (NPR > 1) ? $clog2(NPR) : 1,
    localparam int unsigned CW      = $clog2(NPR + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             alloc_cnt,
    input  logic                      commit_en,
    input  logic [PW-1:0]             freed_tag,
    input  logic                      recover,
    output logic [LANES-1:0][PW-1:0]  head_tags,
    output logic [CW-1:0]             free_cnt
);
    typedef struct packed {
        logic [NPR-1:0][PW-1:0] slot;
        logic [IW-1:0]          head;
        logic [IW-1:0]          chead;
        logic [CW-1:0]          used;
    } fq_state_t;

    fq_state_t st_d, st_q;

    function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] p, input logic [CW-1:0] k);
        int unsigned s;
        s = int'(p) + int'(k);
        if (s >= NPR) s = s - NPR;
        return IW'(s);
    endfunction

    function automatic fq_state_t init_state();
        fq_state_t s;
        for (int i = 0; i < NPR; i++) begin
            s.slot[i] = PW'(rn_pkg::RN_LOG_REGS + i);
        end
        s.head  = '0;
        s.chead = '0;
        s.used  = '0;
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (commit_en) begin
            // the committed slot becomes the tail and takes the released tag
            st_d.slot[st_q.chead] = freed_tag;
            st_d.chead            = wrap_add(st_q.chead, CW'(1));
        end
        st_d.head = wrap_add(st_q.head, alloc_cnt);
        st_d.used = st_q.used + alloc_cnt - CW'(commit_en);
        if (recover) begin
            st_d.head = st_d.chead;
            st_d.used = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= init_state();
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_head
        assign head_tags[k] = st_q.slot[wrap_add(st_q.head, CW'(k))];
    end

    assign free_cnt = CW'(NPR) - st_q.used;
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map #(
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned NL      = rn_pkg::RN_LOG_REGS,
    localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmt_valid,
    input  rn_pkg::lreg_t          cmt_log,
    input  logic [PW-1:0]          cmt_phys,
    output logic [PW-1:0]          old_tag,
    output logic [NL-1:0][PW-1:0]  map_next
);
    typedef struct packed {
        logic [NL-1:0][PW-1:0] map;
    } cm_state_t;

    cm_state_t st_d, st_q;

    function automatic cm_state_t init_state();
        cm_state_t s;
        for (int i = 0; i < NL; i++) s.map[i] = PW'(i);
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (cmt_valid) st_d.map[cmt_log] = cmt_phys;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= init_state();
        else        st_q <= st_d;
    end

    assign old_tag  = st_q.map[cmt_log];
    assign map_next = st_d.map;
endmodule

// File: rtl/rn_spec_map.sv
module rn_spec_map #(
    parameter int unsigned NUM_PHYS = 64,
    parameter int unsigned LANES    = 2,
    localparam int unsigned NL      = rn_pkg::RN_LOG_REGS,
    localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [LANES-1:0]                req_valid,
    input  logic                            accept,
    input  rn_pkg::lreg_t [LANES-1:0]       src_a,
    input  rn_pkg::lreg_t [LANES-1:0]       src_b,
    input  rn_pkg::lreg_t [LANES-1:0]       dst,
    input  logic [LANES-1:0][PW-1:0]        new_tag,
    input  logic                            restore,
    input  logic [NL-1:0][PW-1:0]           restore_map,
    output logic [LANES-1:0][PW-1:0]        tag_a,
    output logic [LANES-1:0][PW-1:0]        tag_b
);
    typedef struct packed {
        logic [NL-1:0][PW-1:0] map;
    } sm_state_t;

    sm_state_t st_d, st_q;

    function automatic sm_state_t init_state();
        sm_state_t s;
        for (int i = 0; i < NL; i++) s.map[i] = PW'(i);
        return s;
    endfunction

    // table read with forwarding from lower lanes of the same group
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            tag_a[k] = st_q.map[src_a[k]];
            tag_b[k] = st_q.map[src_b[k]];
            for (int j = 0; j < k; j++) begin
                if (req_valid[j] && dst[j] == src_a[k]) tag_a[k] = new_tag[j];
                if (req_valid[j] && dst[j] == src_b[k]) tag_b[k] = new_tag[j];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            for (int k = 0; k < LANES; k++) begin
                if (req_valid[k]) st_d.map[dst[k]] = new_tag[k];
            end
        end
        if (restore) st_d.map = restore_map;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= init_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int unsigned NUM_PHYS = 64,
    parameter int unsigned LANES    = 2,
    localparam int unsigned NL      = rn_pkg::RN_LOG_REGS,
    localparam int unsigned LW      = rn_pkg::RN_LOG_W,
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned NPR     = NUM_PHYS - NL,
    localparam int unsigned CW      = $clog2(NPR + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LANES-1:0]               ren_valid,
    input  logic [LANES-1:0][LW-1:0]       ren_src_a,
    input  logic [LANES-1:0][LW-1:0]       ren_src_b,
    input  logic [LANES-1:0][LW-1:0]       ren_dst,
    output logic [LANES-1:0][PW-1:0]       ren_tag_a,
    output logic [LANES-1:0][PW-1:0]       ren_tag_b,
    output logic [LANES-1:0][PW-1:0]       ren_tag_d,
    output logic                           ren_stall,
    input  logic                           cmt_valid,
    input  logic [LW-1:0]                  cmt_log,
    input  logic [PW-1:0]                  cmt_phys,
    input  logic                           recover
);
    logic [LANES-1:0][PW-1:0] head_tags;
    logic [CW-1:0]            free_cnt;
    logic [CW-1:0]            nreq;
    logic [CW-1:0]            alloc_cnt;
    logic                     accept;
    logic [PW-1:0]            old_tag;
    logic [NL-1:0][PW-1:0]    cmap_next;

    // lane k takes the queue entry after those of the valid lanes below it
    always_comb begin
        nreq = '0;
        for (int k = 0; k < LANES; k++) begin
            ren_tag_d[k] = head_tags[int'(nreq)];
            if (ren_valid[k]) nreq = nreq + CW'(1);
        end
    end

    assign ren_stall = recover | (nreq > free_cnt);
    assign accept    = (|ren_valid) & ~ren_stall;
    assign alloc_cnt = accept ? nreq : '0;

    rn_free_queue #(.NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_cnt (alloc_cnt),
        .commit_en (cmt_valid),
        .freed_tag (old_tag),
        .recover   (recover),
        .head_tags (head_tags),
        .free_cnt  (free_cnt)
    );

    rn_commit_map #(.NUM_PHYS(NUM_PHYS)) u_cmap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmt_valid (cmt_valid),
        .cmt_log   (cmt_log),
        .cmt_phys  (cmt_phys),
        .old_tag   (old_tag),
        .map_next  (cmap_next)
    );

    rn_spec_map #(.NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_smap (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (ren_valid),
        .accept      (accept),
        .src_a       (ren_src_a),
        .src_b       (ren_src_b),
        .dst         (ren_dst),
        .new_tag     (ren_tag_d),
        .restore     (recover),
        .restore_map (cmap_next),
        .tag_a       (ren_tag_a),
        .tag_b       (ren_tag_b)
    );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
    parameter int unsigned NUM_PHYS = 64,
    parameter int unsigned LANES    = 2,
    localparam int unsigned PW      = $clog2(NUM_PHYS),
    localparam int unsigned NPR     = NUM_PHYS - rn_pkg::RN_LOG_REGS,
    localparam int unsigned CW      = $clog2(NPR + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [LANES-1:0]          ren_valid,
    input logic [LANES-1:0][PW-1:0]  ren_tag_d,
    input logic                      ren_stall,
    input logic                      cmt_valid,
    input logic                      recover,
    input logic [CW-1:0]             free_cnt,
    input logic [CW-1:0]             nreq,
    input logic                      accept
);
    p_free_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) <= NPR);

    p_stall_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nreq > free_cnt) |-> ren_stall);

    p_recover_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recover |-> ren_stall);

    p_recover_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> int'(free_cnt) == NPR);

    p_alloc_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmt_valid && !recover) |=> free_cnt == $past(free_cnt) - $past(nreq));

    p_commit_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !accept && !recover) |=> int'(free_cnt) == int'($past(free_cnt)) + 1);

    for (genvar j = 0; j < LANES; j++) begin : g_pj
        for (genvar k = j + 1; k < LANES; k++) begin : g_pk
            p_dst_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && ren_valid[j] && ren_valid[k]) |-> ren_tag_d[j] != ren_tag_d[k]);
        end
    end
endmodule

bind rename_unit rename_unit_chk #(.NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_chk (.*);

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PHYS   = 38;
    localparam int LANES      = 2;
    localparam int PW         = $clog2(NUM_PHYS);

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [LANES-1:0]          ren_valid = '0;
    logic [LANES-1:0][4:0]     ren_src_a = '0;
    logic [LANES-1:0][4:0]     ren_src_b = '0;
    logic [LANES-1:0][4:0]     ren_dst = '0;
    logic [LANES-1:0][PW-1:0]  ren_tag_a;
    logic [LANES-1:0][PW-1:0]  ren_tag_b;
    logic [LANES-1:0][PW-1:0]  ren_tag_d;
    logic                      ren_stall;
    logic                      cmt_valid = 1'b0;
    logic [4:0]                cmt_log = '0;
    logic [PW-1:0]             cmt_phys = '0;
    logic                      recover = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_unit #(.NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_dut (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    string phase = "";

    // reference state
    int smap[32];
    int cmap[32];
    int fq[$];
    int ifl_log[$];
    int ifl_phys[$];

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) begin smap[i] = i; cmap[i] = i; end
        fq.delete(); ifl_log.delete(); ifl_phys.delete();
        for (int i = 32; i < NUM_PHYS; i++) fq.push_back(i);
    endfunction

    task automatic cyc(input logic [1:0] v, input int a0, input int b0, input int d0,
                       input int a1, input int b1, input int d1, input bit cm, input bit rc);
        int a[2]; int b[2]; int d[2]; int ed[2]; int ea; int eb;
        int n; int slot; bit exp_stall; string la; string lb;
        a[0] = a0; a[1] = a1; b[0] = b0; b[1] = b1; d[0] = d0; d[1] = d1;
        @(negedge clk);
        ren_valid = v;
        for (int k = 0; k < 2; k++) begin
            ren_src_a[k] = a[k][4:0]; ren_src_b[k] = b[k][4:0]; ren_dst[k] = d[k][4:0];
        end
        cmt_valid = cm;
        if (cm) begin cmt_log = ifl_log[0][4:0]; cmt_phys = ifl_phys[0][PW-1:0]; end
        recover = rc;
        #1;
        n = int'(v[0]) + int'(v[1]);
        exp_stall = rc || (n > fq.size());
        chk(int'(ren_stall), int'(exp_stall), rc ? "R7" : "R4", "stall");
        if (!exp_stall) begin
            slot = 0;
            for (int k = 0; k < 2; k++) begin
                if (v[k]) begin
                    ed[k] = fq[slot]; slot++;
                    ea = smap[a[k]]; eb = smap[b[k]];
                    la = (ea != a[k]) ? "R3" : "R2";
                    lb = (eb != b[k]) ? "R3" : "R2";
                    for (int j = 0; j < k; j++) begin
                        if (v[j] && d[j] == a[k]) begin ea = ed[j]; la = "R5"; end
                        if (v[j] && d[j] == b[k]) begin eb = ed[j]; lb = "R5"; end
                    end
                    if (phase != "") begin la = phase; lb = phase; end
                    chk(int'(ren_tag_a[k]), ea, la, $sformatf("lane%0d src_a", k));
                    chk(int'(ren_tag_b[k]), eb, lb, $sformatf("lane%0d src_b", k));
                    chk(int'(ren_tag_d[k]), ed[k], (phase != "") ? phase : "R2",
                        $sformatf("lane%0d dst", k));
                end
            end
        end
        @(posedge clk);
        if (!exp_stall) begin
            for (int k = 0; k < 2; k++) begin
                if (v[k]) begin
                    int t;
                    t = fq.pop_front();
                    smap[d[k]] = t;
                    ifl_log.push_back(d[k]);
                    ifl_phys.push_back(t);
                end
            end
        end
        if (cm) begin
            int l; int p;
            l = ifl_log.pop_front();
            p = ifl_phys.pop_front();
            fq.push_back(cmap[l]);
            cmap[l] = p;
        end
        if (rc) begin
            for (int i = 0; i < 32; i++) smap[i] = cmap[i];
            for (int i = ifl_phys.size() - 1; i >= 0; i--) fq.push_front(ifl_phys[i]);
            ifl_log.delete(); ifl_phys.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: identity map and ascending spare tags
        phase = "R1";
        cyc(2'b01, 0, 31, 4, 0, 0, 0, 0, 0);
        // R5: lane 1 reads lane 0's new destination
        phase = "R5";
        cyc(2'b11, 7, 8, 10, 10, 10, 11, 0, 0);
        // R3: same destination in both lanes, higher lane kept
        phase = "";
        cyc(2'b11, 1, 2, 12, 3, 4, 12, 0, 0);
        // R4: one free tag left, two lanes requested -> whole group dropped
        phase = "R4";
        cyc(2'b11, 12, 12, 13, 12, 12, 14, 0, 0);
        phase = "R3";
        cyc(2'b01, 12, 10, 13, 0, 0, 0, 0, 0);
        phase = "R4";
        cyc(2'b01, 0, 0, 5, 0, 0, 0, 0, 0);
        // R6: freed tag not usable in the commit cycle, usable after
        phase = "R6";
        cyc(2'b01, 4, 4, 6, 0, 0, 0, 1, 0);
        cyc(2'b01, 4, 13, 6, 0, 0, 0, 0, 0);
        // R7: recover together with a commit
        phase = "R7";
        cyc(2'b11, 4, 10, 2, 12, 13, 3, 1, 1);
        cyc(2'b11, 4, 10, 12, 12, 13, 3, 0, 0);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, 0, 1);
        cyc(2'b11, 4, 12, 20, 13, 3, 21, 0, 0);
        phase = "";

        for (int it = 0; it < 4000; it++) begin
            logic [1:0] v; bit cm; bit rc; int m;
            int r[6];
            v  = 2'($urandom_range(0, 3));
            m  = ($urandom_range(0, 3) == 0) ? 31 : 5;
            for (int q = 0; q < 6; q++) r[q] = $urandom_range(0, m);
            cm = (ifl_log.size() > 0) && ($urandom_range(0, 2) != 0);
            rc = ($urandom_range(0, 39) == 0);
            cyc(v, r[0], r[1], r[2], r[3], r[4], r[5], cm, rc);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule